// File: doc/BRIEF.md
# Single/Dual-Address DMA Channel Sequencer

This block is one DMA channel: a small configuration register set and a sequencer that moves data one unit per request. Software programs a transfer count and one or two addresses, picks how the channel moves data, then arms the channel. While armed, a request starts the next unit. A request is either an active-low pin or an internal trigger line chosen by a select field.

In dual-address mode each unit takes two bus cycles. The first reads from the source address into a holding register. The second writes that data to the destination address. In single-address (fly-by) mode each unit takes one bus cycle. During that cycle the channel raises an I/O acknowledge so that the peripheral drives or takes the data. The channel drives only the memory address, and the access direction comes from a direction bit.

Every unit decrements the count and advances the addresses. When the count reaches zero, the hardware disarms the channel and raises a one-cycle done pulse. The bus side is a valid/ready handshake. Once `bus_valid` is raised, the address, write flag, write data and acknowledge stay unchanged until the cycle in which `bus_ready` is high, so the bus may stall the channel for any number of cycles. A unit moves on the clock edge where both signals are high.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, all four registers read zero: the channel is disarmed, in single mode, with direction 0, trigger select 0, count 0 and both addresses 0.
- R2: The register map uses `cfg_addr` 0 for control, 1 for the count, 2 for the memory/source address and 3 for the destination address. In the control register, bit 0 is arm, bit 1 is mode (1 = dual) and bit 2 is direction (1 = I/O to memory, a memory write). Bits 5:3 are the trigger select. All fields read back.
- R3: A unit starts only while the channel is armed with a nonzero count, and only on `dreq_n` low or on `trig[k-1]` high when the select is k (select 0 picks no trigger). Without these, no bus cycle occurs.
- R4: In dual mode a unit is a read (`bus_we`=0) at the source address, then a write (`bus_we`=1) of the captured data at the destination address. `io_ack` stays low, and the direction bit has no effect.
- R5: In single mode a unit is one bus cycle with `io_ack`=1, `bus_we` equal to the direction bit and `bus_addr` equal to the memory address.
- R6: Each completed unit decrements the count by 1 and advances the memory address by UNIT. The destination address advances by UNIT in dual mode only.
- R7: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_we`, `bus_wdata` and `io_ack` hold their values.
- R8: When the final unit completes, the hardware clears arm. `done` is high for exactly the one cycle after the final handshake.
- R9: Arming with a count of zero produces no bus cycle. It clears arm and pulses `done` once.
- R10: While the channel is armed or a unit is in flight, writes to the count, the addresses and the non-arm control fields are ignored. The arm bit stays writable, and writing 0 stops new units.
- R11: When a software write of the control register falls in the same cycle as the hardware clear, the clear wins. Arm reads 0 and `done` pulses only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| dreq_n | input | 1 | External request, active low |
| trig | input | NTRIG | Internal trigger lines |
| bus_valid | output | 1 | Bus cycle requested |
| bus_ready | input | 1 | Bus accepts the cycle |
| bus_we | output | 1 | 1 = memory write, 0 = memory read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data (dual-mode store) |
| bus_rdata | input | DW | Read data, taken on the read handshake |
| io_ack | output | 1 | I/O acknowledge during a fly-by cycle |
| done | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
The hardware clear of arm on the final handshake and a software write of the control register can land on the same clock edge. The bench provokes this in single mode with the bus always ready. It waits for the cycle in which the only fly-by cycle is on the bus, then writes arm=1 so that the write hits the completing edge. It judges the result at the ports: arm must read 0 afterwards, exactly one done pulse must appear, and no further bus cycle may follow. Randomized transfers with random bus stalls also cover the same edge for the count update and the stall-hold rule.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2,
    ST_FLY   = 2'd3
  } seq_state_e;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_COUNT = 2'd1;
  localparam logic [1:0] RA_MADDR = 2'd2;
  localparam logic [1:0] RA_DADDR = 2'd3;

  localparam int CB_ARM   = 0;
  localparam int CB_DUAL  = 1;
  localparam int CB_TOMEM = 2;
  localparam int CB_TSEL  = 3;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_chan_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int TSW  = 3,
  parameter int UNIT = 4,
  parameter int RW   = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_addr,
  input  logic [RW-1:0]  cfg_wdata,
  output logic [RW-1:0]  cfg_rdata,
  input  logic           busy,
  input  logic           unit_done,
  output logic           arm,
  output logic           dual,
  output logic           tomem,
  output logic [TSW-1:0] tsel,
  output logic [CW-1:0]  cnt,
  output logic [AW-1:0]  maddr,
  output logic [AW-1:0]  daddr,
  output logic           done
);

  logic locked;
  logic last_unit;
  logic zero_fin;
  logic finish;
  logic wr_ctrl;

  assign locked    = arm | busy;
  assign last_unit = unit_done && (cnt == CW'(1));
  assign zero_fin  = arm && !busy && (cnt == '0);
  assign finish    = last_unit | zero_fin;
  assign wr_ctrl   = cfg_we && (cfg_addr == RA_CTRL);

  // arm: hardware clear has priority over a software write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= finish;
      if (finish)       arm <= 1'b0;
      else if (wr_ctrl) arm <= cfg_wdata[CB_ARM];
    end
  end

  // setup fields: writable only while idle and disarmed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dual  <= 1'b0;
      tomem <= 1'b0;
      tsel  <= '0;
      cnt   <= '0;
      maddr <= '0;
      daddr <= '0;
    end else if (unit_done) begin
      cnt   <= cnt - CW'(1);
      maddr <= maddr + AW'(UNIT);
      if (dual) daddr <= daddr + AW'(UNIT);
    end else if (cfg_we && !locked) begin
      case (cfg_addr)
        RA_CTRL: begin
          dual  <= cfg_wdata[CB_DUAL];
          tomem <= cfg_wdata[CB_TOMEM];
          tsel  <= cfg_wdata[CB_TSEL +: TSW];
        end
        RA_COUNT: cnt   <= cfg_wdata[CW-1:0];
        RA_MADDR: maddr <= cfg_wdata[AW-1:0];
        default:  daddr <= cfg_wdata[AW-1:0];
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      RA_CTRL:  cfg_rdata = RW'({tsel, tomem, dual, arm});
      RA_COUNT: cfg_rdata = RW'(cnt);
      RA_MADDR: cfg_rdata = RW'(maddr);
      default:  cfg_rdata = RW'(daddr);
    endcase
  end

endmodule

// File: rtl/dma_req_pick.sv
module dma_req_pick #(
  parameter int NTRIG = 4,
  parameter int TSW   = 3
) (
  input  logic             pin_n,
  input  logic [NTRIG-1:0] trig,
  input  logic [TSW-1:0]   tsel,
  output logic             want
);

  localparam int NSEL = 1 << TSW;

  logic [NSEL-1:0] tab;

  assign tab[0] = 1'b0;

  for (genvar k = 1; k < NSEL; k++) begin : g_tab
    if (k <= NTRIG) begin : g_on
      assign tab[k] = trig[k-1];
    end else begin : g_off
      assign tab[k] = 1'b0;
    end
  end

  assign want = ~pin_n | tab[tsel];

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          dual,
  input  logic          tomem,
  input  logic          cnt_nz,
  input  logic          want,
  input  logic [AW-1:0] maddr,
  input  logic [AW-1:0] daddr,
  output logic          busy,
  output logic          unit_done,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          io_ack
);

  seq_state_e    state_q;
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (arm && want && cnt_nz) state_q <= dual ? ST_FETCH : ST_FLY;
        end
        ST_FETCH: begin
          if (bus_ready) begin
            hold_q  <= bus_rdata;
            state_q <= ST_STORE;
          end
        end
        ST_STORE: if (bus_ready) state_q <= ST_IDLE;
        default:  if (bus_ready) state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state_q != ST_IDLE);
    bus_valid = busy;
    io_ack    = (state_q == ST_FLY);
    unit_done = bus_ready && ((state_q == ST_STORE) || (state_q == ST_FLY));
    bus_wdata = (state_q == ST_STORE) ? hold_q : '0;
    bus_addr  = (state_q == ST_STORE) ? daddr : maddr;
    case (state_q)
      ST_STORE: bus_we = 1'b1;
      ST_FLY:   bus_we = tomem;
      default:  bus_we = 1'b0;
    endcase
  end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 16,
  parameter int NTRIG = 4,
  parameter int UNIT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             dreq_n,
  input  logic [NTRIG-1:0] trig,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  output logic             io_ack,
  output logic             done
);

  localparam int TSW = $clog2(NTRIG + 1);
  localparam int RW  = 32;

  logic           ch_arm;
  logic           ch_dual;
  logic           ch_tomem;
  logic [TSW-1:0] ch_tsel;
  logic [CW-1:0]  ch_cnt;
  logic [AW-1:0]  ch_maddr;
  logic [AW-1:0]  ch_daddr;
  logic           ch_busy;
  logic           ch_unit_done;
  logic           ch_want;

  dma_cfg_regs #(
    .AW(AW), .CW(CW), .TSW(TSW), .UNIT(UNIT), .RW(RW)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .busy      (ch_busy),
    .unit_done (ch_unit_done),
    .arm       (ch_arm),
    .dual      (ch_dual),
    .tomem     (ch_tomem),
    .tsel      (ch_tsel),
    .cnt       (ch_cnt),
    .maddr     (ch_maddr),
    .daddr     (ch_daddr),
    .done      (done)
  );

  dma_req_pick #(
    .NTRIG(NTRIG), .TSW(TSW)
  ) u_pick (
    .pin_n (dreq_n),
    .trig  (trig),
    .tsel  (ch_tsel),
    .want  (ch_want)
  );

  dma_seq #(
    .AW(AW), .DW(DW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (ch_arm),
    .dual      (ch_dual),
    .tomem     (ch_tomem),
    .cnt_nz    (|ch_cnt),
    .want      (ch_want),
    .maddr     (ch_maddr),
    .daddr     (ch_daddr),
    .busy      (ch_busy),
    .unit_done (ch_unit_done),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .io_ack    (io_ack)
  );

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          io_ack,
  input logic          done,
  input logic          arm,
  input logic          dual,
  input logic [CW-1:0] cnt
);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_wdata) && $stable(io_ack)));

  assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    io_ack |-> (bus_valid && !dual));

  assert_fetch_then_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !io_ack && !bus_we) |=> (bus_valid && bus_we && !io_ack));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && (io_ack || bus_we)) |=> (cnt == CW'($past(cnt) - CW'(1))));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_disarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !arm);

  assert_no_bus_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (cnt != '0));

endmodule

bind dma_chan_seq dma_chan_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .io_ack    (io_ack),
  .done      (done),
  .arm       (ch_arm),
  .dual      (ch_dual),
  .cnt       (ch_cnt)
);

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
  localparam int AW = 32, DW = 32, CW = 16, NTRIG = 4, UNIT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_addr = 2'd0;
  logic [31:0]      cfg_wdata = '0;
  logic [31:0]      cfg_rdata;
  logic             dreq_n = 1'b1;
  logic [NTRIG-1:0] trig = '0;
  logic             bus_valid;
  logic             bus_ready = 1'b0;
  logic             bus_we;
  logic [AW-1:0]    bus_addr;
  logic [DW-1:0]    bus_wdata;
  logic [DW-1:0]    bus_rdata = '0;
  logic             io_ack;
  logic             done;

  dma_chan_seq #(.AW(AW), .DW(DW), .CW(CW), .NTRIG(NTRIG), .UNIT(UNIT)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq_n(dreq_n), .trig(trig),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .io_ack(io_ack), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  int rdy_pct = 100;
  int nlog = 0;
  int ndone = 0;
  logic [31:0] mem [0:255];
  logic        log_we   [0:63];
  logic        log_io   [0:63];
  logic [31:0] log_addr [0:63];
  logic [31:0] src_exp  [0:15];

  // bus model: decide ready at negedge; a handshake then occurs at next posedge
  always @(negedge clk) begin
    if (done) ndone++;
    bus_ready = ($urandom_range(99) < rdy_pct);
    if (bus_valid && bus_ready) begin
      if (nlog < 64) begin
        log_we[nlog]   = bus_we;
        log_io[nlog]   = io_ack;
        log_addr[nlog] = bus_addr;
      end
      nlog++;
      if (!io_ack && bus_we) mem[bus_addr[9:2]] = bus_wdata;
      else if (!io_ack)      bus_rdata = mem[bus_addr[9:2]];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input bit arm, input bit dual, input bit dir,
                                            input logic [2:0] tsel);
    return {26'd0, tsel, dir, dual, arm};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input int start, input string tag);
    int k;
    k = 0;
    while (ndone == start && k < 4000) begin
      @(negedge clk); #1; k++;
    end
    chk({tag, " completes"}, (ndone > start) ? 32'd1 : 32'd0, 32'd1);
  endtask

  task automatic run_xfer(input bit dual, input bit dir, input int count,
                          input logic [31:0] mbase, input logic [31:0] dbase, input int pct);
    int start, bad;
    logic [31:0] v;
    rdy_pct = pct;
    for (int i = 0; i < count; i++) begin
      src_exp[i] = $urandom;
      mem[mbase[9:2] + 8'(i)] = src_exp[i];
      mem[dbase[9:2] + 8'(i)] = ~src_exp[i];
    end
    wr(2'd1, 32'(count));
    wr(2'd2, mbase);
    wr(2'd3, dbase);
    nlog = 0;
    start = ndone;
    dreq_n = 1'b0;
    wr(2'd0, ctrl_word(1'b1, dual, dir, 3'd0));
    wait_done(start, "R8 transfer");
    dreq_n = 1'b1;
    idle(4);
    chk("R8 single done pulse", 32'(ndone - start), 32'd1);
    rd(2'd0, v); chk("R8 arm cleared", v & 32'd1, 32'd0);
    rd(2'd1, v); chk("R6 count at end", v, 32'd0);
    rd(2'd2, v); chk("R6 memory address end", v, mbase + 32'(UNIT * count));
    rd(2'd3, v); chk("R6 destination address end", v, dual ? dbase + 32'(UNIT * count) : dbase);
    if (dual) begin
      chk("R4 bus cycles per dual run", 32'(nlog), 32'(2 * count));
      bad = 0;
      for (int i = 0; i < count; i++) begin
        if (log_we[2*i] !== 1'b0 || log_io[2*i] !== 1'b0 || log_addr[2*i] !== mbase + 32'(UNIT*i)) bad++;
        if (log_we[2*i+1] !== 1'b1 || log_io[2*i+1] !== 1'b0 || log_addr[2*i+1] !== dbase + 32'(UNIT*i)) bad++;
        if (mem[dbase[9:2] + 8'(i)] !== src_exp[i]) bad++;
      end
      chk(dir ? "R4 dual order and data, direction bit 1 ignored" : "R4 dual order and data", 32'(bad), 32'd0);
    end else begin
      chk("R5 bus cycles per single run", 32'(nlog), 32'(count));
      bad = 0;
      for (int i = 0; i < count; i++) begin
        if (log_io[i] !== 1'b1 || log_we[i] !== dir || log_addr[i] !== mbase + 32'(UNIT*i)) bad++;
      end
      chk("R5 fly-by cycles", 32'(bad), 32'd0);
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int start;
    bit found;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 control after reset", v, 32'd0);
    rd(2'd1, v); chk("R1 count after reset", v, 32'd0);
    rd(2'd2, v); chk("R1 memory address after reset", v, 32'd0);
    rd(2'd3, v); chk("R1 destination address after reset", v, 32'd0);

    // R2 readback while disarmed
    wr(2'd1, 32'd5);
    wr(2'd2, 32'h40);
    wr(2'd3, 32'h200);
    wr(2'd0, ctrl_word(1'b0, 1'b1, 1'b1, 3'd3));
    rd(2'd0, v); chk("R2 control readback", v, 32'h1E);
    rd(2'd1, v); chk("R2 count readback", v, 32'd5);
    rd(2'd2, v); chk("R2 memory address readback", v, 32'h40);
    rd(2'd3, v); chk("R2 destination address readback", v, 32'h200);
    wr(2'd0, 32'd0);

    // R3 request ignored while disarmed
    nlog = 0;
    wr(2'd1, 32'd3);
    dreq_n = 1'b0;
    idle(20);
    dreq_n = 1'b1;
    chk("R3 no bus cycle while disarmed", 32'(nlog), 32'd0);
    rd(2'd1, v); chk("R3 count untouched while disarmed", v, 32'd3);

    // R3 trigger selection
    rdy_pct = 100;
    wr(2'd1, 32'd1);
    wr(2'd2, 32'h80);
    nlog = 0;
    start = ndone;
    wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 3'd2));
    trig = 4'b0001;
    idle(10);
    chk("R3 unselected trigger ignored", 32'(nlog), 32'd0);
    trig = 4'b0010;
    wait_done(start, "R3 selected trigger");
    trig = '0;
    chk("R3 selected trigger moves one unit", 32'(nlog), 32'd1);

    // R10 writes ignored while armed
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd4);
    wr(2'd2, 32'h10);
    wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 3'd0));
    wr(2'd1, 32'd9);
    wr(2'd2, 32'h84);
    wr(2'd3, 32'h300);
    wr(2'd0, ctrl_word(1'b1, 1'b1, 1'b1, 3'd1));
    rd(2'd1, v); chk("R10 count locked", v, 32'd4);
    rd(2'd2, v); chk("R10 memory address locked", v, 32'h10);
    rd(2'd3, v); chk("R10 destination address locked", v, 32'h200);
    rd(2'd0, v); chk("R10 control fields locked", v, 32'd1);
    wr(2'd0, 32'd0);
    rd(2'd0, v); chk("R10 arm writable to 0", v, 32'd0);
    wr(2'd1, 32'd7);
    rd(2'd1, v); chk("R10 count writable when disarmed", v, 32'd7);

    // R9 zero count
    wr(2'd1, 32'd0);
    nlog = 0;
    start = ndone;
    dreq_n = 1'b0;
    wr(2'd0, ctrl_word(1'b1, 1'b1, 1'b0, 3'd0));
    idle(10);
    dreq_n = 1'b1;
    chk("R9 no bus cycle at zero count", 32'(nlog), 32'd0);
    chk("R9 one done pulse", 32'(ndone - start), 32'd1);
    rd(2'd0, v); chk("R9 arm cleared", v & 32'd1, 32'd0);

    // R11 hardware clear vs software arm write on the same edge
    rdy_pct = 100;
    wr(2'd1, 32'd1);
    wr(2'd2, 32'h20);
    nlog = 0;
    start = ndone;
    dreq_n = 1'b0;
    wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b1, 3'd0));
    found = 1'b0;
    for (int k = 0; k < 20 && !found; k++) begin
      @(negedge clk);
      if (bus_valid && io_ack) begin
        found = 1'b1;
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = ctrl_word(1'b1, 1'b0, 1'b1, 3'd0);
        @(negedge clk);
        cfg_we = 1'b0;
      end
    end
    idle(10);
    dreq_n = 1'b1;
    chk("R11 collision reached", 32'(found), 32'd1);
    rd(2'd0, v); chk("R11 hardware clear wins", v & 32'd1, 32'd0);
    chk("R11 single done pulse", 32'(ndone - start), 32'd1);
    chk("R11 no extra bus cycle", 32'(nlog), 32'd1);

    // directed: dual with direction bit set, stalls
    run_xfer(1'b1, 1'b1, 4, 32'h100, 32'h240, 40);
    run_xfer(1'b0, 1'b0, 3, 32'h30, 32'h280, 60);

    // randomized runs (R7 stall hold is covered by the bound checker)
    for (int it = 0; it < 10; it++) begin
      run_xfer(1'($urandom_range(1)), 1'($urandom_range(1)), $urandom_range(1, 8),
               32'(4 * $urandom_range(0, 40)), 32'(4 * (128 + $urandom_range(0, 40))),
               $urandom_range(25, 100));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule